// File: doc/BRIEF.md
# Two-Bit Function-Coded ALU

A narrow arithmetic and logic unit that evaluates one of nine operations on two-bit operands when its evaluate strobe fires. Three operand inputs are presented: A and B carry the data, and C supplies a selector bit for the conditional-pick operation. A four-bit function code picks the operation. The unit holds a registered two-bit result and a one-bit carry flag. Both change only on a clock edge where the strobe is high.

The strobe is meant to be raised by whatever writes the function code. Writing the same code twice therefore evaluates twice. The stored carry feeds the chained add and chained negate operations. This lets multi-word sums and two's-complement differences be built two bits at a time. Logic, compare and select operations never disturb the stored carry. Unassigned codes yield a zero result and also leave the carry alone.

Top module: `alu2_top`

## Requirements
- R1: A synchronous active-high reset sets the result to 0 and the carry to 0 on the next clock edge.
- R2: On an edge where the strobe is low, the result and the carry keep their values, whatever the code and operands are.
- R3: Code 0 loads (A+B) mod 4 into the result and sets the carry exactly when A+B exceeds 3.
- R4: Code 8 loads (A+B+K) mod 4 into the result, where K is the stored carry, and sets the carry exactly when that sum exceeds 3.
- R5: Code 1 loads (0−A) mod 4 into the result and sets the carry exactly when A is nonzero.
- R6: Code 9 loads (0−A−K) mod 4 into the result and sets the carry exactly when 0−A−K is negative.
- R7: Code 2 loads 1 when B is greater than A (unsigned) and 0 otherwise.
- R8: Code 3 loads B when bit 0 of C is 1 and loads A otherwise. Bit 1 of C has no effect.
- R9: Code 4 loads A AND B, code 5 loads 3−A (bitwise NOT), and code 6 loads A OR B.
- R10: Codes 2 through 6 leave the carry unchanged.
- R11: Codes 7 and 10 through 15 load a result of 0 and leave the carry unchanged.
- R12: A strobe with an unchanged code re-evaluates the function. For example, two back-to-back code-8 strobes add the stored carry twice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| eval_i | input | 1 | Evaluate strobe, high for one cycle per function-code write |
| func_i | input | 4 | Function code |
| opa_i | input | 2 | Operand A |
| opb_i | input | 2 | Operand B |
| opc_i | input | 2 | Select operand C (bit 0 used) |
| res_o | output | 2 | Registered result |
| cry_o | output | 1 | Registered carry / borrow flag |

## Verification
Every code is swept over all A, B and C combinations, once with the stored carry at 0 and once at 1. This separates the chained operations from their plain forms. It also shows that the carry-neutral codes truly ignore and keep the flag. The unused bit of C is swept along with the rest, so a decoder that looks at the wrong selector bit shows up. Idle cycles with random operands check that nothing changes without a strobe. A back-to-back repeat of the chained add, plus a reset raised together with the strobe, covers re-evaluation and reset priority.

// File: rtl/alu2_pkg.sv
package alu2_pkg;

  localparam int FUNC_W = 4;

  typedef enum logic [FUNC_W-1:0] {
    FN_ADD  = 4'd0,
    FN_NEG  = 4'd1,
    FN_GT   = 4'd2,
    FN_SEL  = 4'd3,
    FN_AND  = 4'd4,
    FN_NOT  = 4'd5,
    FN_OR   = 4'd6,
    FN_ADDC = 4'd8,
    FN_NEGB = 4'd9
  } fn_e;

  typedef enum logic [1:0] {
    GRP_ARITH = 2'd0,
    GRP_LOGIC = 2'd1,
    GRP_NONE  = 2'd2
  } grp_e;

  typedef struct packed {
    grp_e grp;
    logic neg;     // negate path instead of add path
    logic chain;   // use the stored carry
  } dec_t;

  function automatic dec_t decode_fn(input logic [FUNC_W-1:0] code);
    dec_t d;
    d = '{grp: GRP_NONE, neg: 1'b0, chain: 1'b0};
    case (code)
      FN_ADD:  d = '{grp: GRP_ARITH, neg: 1'b0, chain: 1'b0};
      FN_ADDC: d = '{grp: GRP_ARITH, neg: 1'b0, chain: 1'b1};
      FN_NEG:  d = '{grp: GRP_ARITH, neg: 1'b1, chain: 1'b0};
      FN_NEGB: d = '{grp: GRP_ARITH, neg: 1'b1, chain: 1'b1};
      FN_GT, FN_SEL, FN_AND, FN_NOT, FN_OR:
               d = '{grp: GRP_LOGIC, neg: 1'b0, chain: 1'b0};
      default: d = '{grp: GRP_NONE, neg: 1'b0, chain: 1'b0};
    endcase
    return d;
  endfunction

endpackage

// File: rtl/alu2_arith.sv
module alu2_arith #(
  parameter int W = 2
) (
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic         neg_i,
  input  logic         chain_i,
  input  logic         cry_i,
  output logic [W-1:0] sum_o,
  output logic         flag_o
);

  // Negate runs as 0 + ~A + (1 - borrow); add runs as A + B + carry.
  logic [W-1:0] lhs;
  logic [W-1:0] rhs;
  logic [W:0]   c;

  always_comb begin
    if (neg_i) begin
      lhs  = '0;
      rhs  = ~opa_i;
      c[0] = chain_i ? ~cry_i : 1'b1;
    end else begin
      lhs  = opa_i;
      rhs  = opb_i;
      c[0] = chain_i ? cry_i : 1'b0;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum_o[i] = lhs[i] ^ rhs[i] ^ c[i];
    assign c[i+1]   = (lhs[i] & rhs[i]) | (c[i] & (lhs[i] ^ rhs[i]));
  end

  // Borrow is the inverse of the carry-out on the negate path.
  assign flag_o = neg_i ? ~c[W] : c[W];

endmodule

// File: rtl/alu2_logic.sv
module alu2_logic
  import alu2_pkg::*;
#(
  parameter int W = 2
) (
  input  logic [FUNC_W-1:0] func_i,
  input  logic [W-1:0]      opa_i,
  input  logic [W-1:0]      opb_i,
  input  logic [W-1:0]      opc_i,
  output logic [W-1:0]      res_o
);

  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    case (func_i)
      FN_GT:   res_o = (opb_i > opa_i) ? ONE : '0;
      FN_SEL:  res_o = opc_i[0] ? opb_i : opa_i;
      FN_AND:  res_o = opa_i & opb_i;
      FN_NOT:  res_o = ~opa_i;
      FN_OR:   res_o = opa_i | opb_i;
      default: res_o = '0;
    endcase
  end

endmodule

// File: rtl/alu2_top.sv
module alu2_top
  import alu2_pkg::*;
#(
  parameter int W = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              eval_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic [W-1:0]      opa_i,
  input  logic [W-1:0]      opb_i,
  input  logic [W-1:0]      opc_i,
  output logic [W-1:0]      res_o,
  output logic              cry_o
);

  dec_t         dec;
  logic [W-1:0] ar_sum;
  logic         ar_flag;
  logic [W-1:0] lg_res;
  logic [W-1:0] res_q;
  logic         cry_q;

  assign dec = decode_fn(func_i);

  alu2_arith #(.W(W)) arith_i (
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .neg_i   (dec.neg),
    .chain_i (dec.chain),
    .cry_i   (cry_q),
    .sum_o   (ar_sum),
    .flag_o  (ar_flag)
  );

  alu2_logic #(.W(W)) logic_i (
    .func_i (func_i),
    .opa_i  (opa_i),
    .opb_i  (opb_i),
    .opc_i  (opc_i),
    .res_o  (lg_res)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      res_q <= '0;
      cry_q <= 1'b0;
    end else if (eval_i) begin
      case (dec.grp)
        GRP_ARITH: begin
          res_q <= ar_sum;
          cry_q <= ar_flag;
        end
        GRP_LOGIC: res_q <= lg_res;
        default:   res_q <= '0;
      endcase
    end
  end

  assign res_o = res_q;
  assign cry_o = cry_q;

endmodule

// File: rtl/alu2_chk.sv
module alu2_chk #(
  parameter int W = 2
) (
  input logic         clk_i,
  input logic         rst_i,
  input logic         eval_i,
  input logic [3:0]   func_i,
  input logic [W-1:0] opa_i,
  input logic [W-1:0] opb_i,
  input logic [W-1:0] opc_i,
  input logic [W-1:0] res_o,
  input logic         cry_o
);

  logic is_lgc;
  logic is_undef;
  assign is_lgc   = (func_i >= 4'd2) && (func_i <= 4'd6);
  assign is_undef = (func_i == 4'd7) || (func_i >= 4'd10);

  a_r1_reset_clear: assert property (@(posedge clk_i)
    rst_i |=> (res_o == '0) && !cry_o);

  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !eval_i |=> $stable(res_o) && $stable(cry_o));

  a_r3_add_sum: assert property (@(posedge clk_i) disable iff (rst_i)
    eval_i && func_i == 4'd0 |=>
      {cry_o, res_o} == ({1'b0, $past(opa_i)} + {1'b0, $past(opb_i)}));

  a_r5_neg_flag: assert property (@(posedge clk_i) disable iff (rst_i)
    eval_i && func_i == 4'd1 |=> cry_o == ($past(opa_i) != '0));

  a_r7_gt_range: assert property (@(posedge clk_i) disable iff (rst_i)
    eval_i && func_i == 4'd2 |=>
      res_o == (($past(opb_i) > $past(opa_i)) ? W'(1) : W'(0)));

  a_r8_sel_pick: assert property (@(posedge clk_i) disable iff (rst_i)
    eval_i && func_i == 4'd3 |=>
      res_o == ($past(opc_i[0]) ? $past(opb_i) : $past(opa_i)));

  a_r10_carry_kept: assert property (@(posedge clk_i) disable iff (rst_i)
    eval_i && is_lgc |=> $stable(cry_o));

  a_r11_undef_zero: assert property (@(posedge clk_i) disable iff (rst_i)
    eval_i && is_undef |=> (res_o == '0) && $stable(cry_o));

  a_r12_chain_add: assert property (@(posedge clk_i) disable iff (rst_i)
    eval_i && func_i == 4'd8 |=>
      {cry_o, res_o} == ({1'b0, $past(opa_i)} + {1'b0, $past(opb_i)}
                         + {{W{1'b0}}, $past(cry_o)}));

endmodule

bind alu2_top alu2_chk #(.W(W)) chk_i (
  .clk_i  (clk_i),
  .rst_i  (rst_i),
  .eval_i (eval_i),
  .func_i (func_i),
  .opa_i  (opa_i),
  .opb_i  (opb_i),
  .opc_i  (opc_i),
  .res_o  (res_o),
  .cry_o  (cry_o)
);

// File: tb/alu2_top_tb_top.sv
`timescale 1ns/1ps
module alu2_top_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       ev;
  logic [3:0] fn;
  logic [1:0] a, b, c;
  logic [1:0] res;
  logic       cry;

  int n_chk = 0;
  int n_bad = 0;
  int m_res = 0;
  int m_cry = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  alu2_top #(.W(2)) dut_i (
    .clk_i (clk), .rst_i (rst), .eval_i (ev), .func_i (fn),
    .opa_i (a), .opb_i (b), .opc_i (c), .res_o (res), .cry_o (cry)
  );

  function automatic string tag_of(int f);
    case (f)
      0: return "R3";
      8: return "R4";
      1: return "R5";
      9: return "R6";
      2: return "R7";
      3: return "R8";
      4, 5, 6: return "R9";
      default: return "R11";
    endcase
  endfunction

  // Behavioural reference: integer arithmetic on the requirements.
  task automatic model(int f, int x, int y, int z);
    int s;
    case (f)
      0: begin s = x + y;         m_res = s % 4; m_cry = (s > 3); end
      8: begin s = x + y + m_cry; m_res = s % 4; m_cry = (s > 3); end
      1: begin s = 0 - x;         m_res = (s + 8) % 4; m_cry = (s < 0); end
      9: begin s = 0 - x - m_cry; m_res = (s + 8) % 4; m_cry = (s < 0); end
      2: m_res = (y > x) ? 1 : 0;
      3: m_res = (z % 2 == 1) ? y : x;
      4: m_res = x & y;
      5: m_res = 3 - x;
      6: m_res = x | y;
      default: m_res = 0;
    endcase
  endtask

  task automatic check(string tr, string tc);
    n_chk++;
    if (int'(res) != m_res) begin
      n_bad++;
      $display("FAIL %s result got %0d expected %0d", tr, res, m_res);
    end
    n_chk++;
    if (int'(cry) != m_cry) begin
      n_bad++;
      $display("FAIL %s carry got %0d expected %0d", tc, cry, m_cry);
    end
  endtask

  // One clock: drive at negedge, update model at the edge, compare at next negedge.
  task automatic step(bit r, bit e, int f, int x, int y, int z, string tag);
    string tr, tc;
    rst = r; ev = e; fn = 4'(f); a = 2'(x); b = 2'(y); c = 2'(z);
    @(posedge clk);
    if (r) begin
      m_res = 0; m_cry = 0;
      tr = "R1"; tc = "R1";
    end else if (!e) begin
      tr = "R2"; tc = "R2";
    end else begin
      model(f, x, y, z);
      tr = tag_of(f);
      tc = (f >= 2 && f <= 6) ? "R10" : tr;
    end
    if (tag != "") begin tr = tag; tc = tag; end
    @(negedge clk);
    check(tr, tc);
  endtask

  initial begin
    rst = 1'b1; ev = 1'b0; fn = '0; a = '0; b = '0; c = '0;
    @(negedge clk);
    step(1, 1, 8, 3, 3, 0, "R1");
    step(0, 0, 0, 0, 0, 0, "R1");

    // Exhaustive sweep with the stored carry forced to each value first.
    for (int f = 0; f < 16; f++)
      for (int k = 0; k < 2; k++)
        for (int x = 0; x < 4; x++)
          for (int y = 0; y < 4; y++)
            for (int z = 0; z < 4; z++) begin
              step(0, 1, 0, 3, k, 0, "");
              step(0, 1, f, x, y, z, "");
            end

    // Idle cycles: strobe low, random code and operands.
    step(0, 1, 0, 3, 1, 0, "");
    for (int i = 0; i < 40; i++)
      step(0, 0, $urandom_range(15), $urandom_range(3),
           $urandom_range(3), $urandom_range(3), "R2");

    // Same code written twice re-evaluates with the new carry.
    step(0, 1, 0, 3, 3, 0, "");
    step(0, 1, 8, 3, 0, 0, "R12");
    step(0, 1, 8, 3, 0, 0, "R12");
    step(0, 1, 9, 0, 0, 0, "R12");
    step(0, 1, 9, 0, 0, 0, "R12");

    // Reset wins over a strobe in the same cycle.
    step(0, 1, 0, 3, 3, 0, "");
    step(1, 1, 0, 3, 3, 0, "R1");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule